// File: doc/BRIEF.md
# Compare-Latch Conditional Branch Unit

This block keeps the two raw operands of the most recent compare operation. It does not reduce them to condition flags. When a conditional branch arrives, the block evaluates that branch's own condition code against the stored pair. It then reports whether the branch is taken and which program counter follows.

Ten condition codes are defined, covering equality and both signed and unsigned orderings. The six remaining codes are reported as illegal and never redirect the flow.

Results are registered. They appear on the cycle after the branch strobe, qualified by a valid flag. A compare and a branch may be presented on the same cycle. In that case the branch sees the operands latched by the earlier compare.

Top module: `cmp_branch_unit`

## Requirements
- R1: After reset both stored operands are zero, and `npc_out`, `npc_valid`, `taken` and `illegal` are all zero.
- R2: When `cmp_valid` is high, `cmp_lhs` is stored as the first operand and `cmp_rhs` as the second. Without `cmp_valid`, both stored operands keep their values.
- R3: The condition code `br_cond` selects one test of the first operand against the second: 0 equal, 1 not equal, 2 signed less, 3 signed greater, 4 unsigned less, 5 unsigned greater, 6 signed greater-or-equal, 7 signed less-or-equal, 8 unsigned greater-or-equal, 9 unsigned less-or-equal.
- R4: Signed tests treat bit 31 as a two's-complement sign. Unsigned tests treat the full 32 bits as a magnitude.
- R5: A taken branch gives `npc_out` = `pc_in` + 2 + (the 10-bit `br_ofs` sign-extended and shifted left by one), modulo 2^32.
- R6: A branch that is not taken gives `npc_out` = `pc_in` + 2, modulo 2^32.
- R7: For condition codes 10 to 15, `illegal` is 1, `taken` is 0 and `npc_out` = `pc_in` + 2. For codes 0 to 9, `illegal` is 0.
- R8: `npc_valid`, `taken`, `illegal` and `npc_out` reflect a branch on the cycle after the cycle in which `br_valid` is sampled high. In a cycle that follows no branch strobe, `npc_valid`, `taken` and `illegal` are 0.
- R9: A branch sampled in the same cycle as a compare is evaluated against the operands stored before that compare. The new operands apply from the next branch onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare strobe |
| cmp_lhs | input | 32 | First compare operand |
| cmp_rhs | input | 32 | Second compare operand |
| br_valid | input | 1 | Branch strobe |
| br_cond | input | 4 | Branch condition code |
| br_ofs | input | 10 | Signed branch offset in halfwords |
| pc_in | input | 32 | Address of the branch instruction |
| npc_out | output | 32 | Next program counter |
| npc_valid | output | 1 | Result valid, one cycle after a branch strobe |
| taken | output | 1 | Branch taken |
| illegal | output | 1 | Undefined condition code seen |

## Verification
The bound checker watches several properties on every cycle:
- Operands are captured on a compare and held without one.
- The result valid flag follows the branch strobe exactly one cycle later.
- An illegal code never coincides with a taken result.
- Every valid result points either at the fall-through address or at the offset target of the previous cycle's PC.

Which of those two addresses is correct for a given operand pair and code depends on the ordering semantics. Only the bench's sweeps can show that: they cover every code against signed and unsigned boundary values, every offset, and address wrap. The same-cycle compare-and-branch ordering is also shown only by a bench scenario.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  localparam int CC_W      = 4;
  localparam int NUM_LEGAL = 10;

  typedef enum logic [CC_W-1:0] {
    CC_EQ  = 4'd0,
    CC_NE  = 4'd1,
    CC_LT  = 4'd2,
    CC_GT  = 4'd3,
    CC_LTU = 4'd4,
    CC_GTU = 4'd5,
    CC_GE  = 4'd6,
    CC_LE  = 4'd7,
    CC_GEU = 4'd8,
    CC_LEU = 4'd9
  } cond_e;

endpackage

// File: rtl/cbu_operand_latch.sv
module cbu_operand_latch #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] lhs_in,
  input  logic [DATA_W-1:0] rhs_in,
  output logic [DATA_W-1:0] lhs_q,
  output logic [DATA_W-1:0] rhs_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lhs_q <= '0;
      rhs_q <= '0;
    end else if (load) begin
      lhs_q <= lhs_in;
      rhs_q <= rhs_in;
    end
  end

endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cbu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [CC_W-1:0]   code,
  output logic              hit,
  output logic              bad_code
);

  function automatic logic lt_signed(input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  function automatic logic lt_unsigned(input logic [DATA_W-1:0] a,
                                       input logic [DATA_W-1:0] b);
    return a < b;
  endfunction

  logic is_eq, s_ab, s_ba, u_ab, u_ba;
  logic [NUM_LEGAL-1:0] res;

  always_comb begin
    is_eq = (opa == opb);
    s_ab  = lt_signed(opa, opb);
    s_ba  = lt_signed(opb, opa);
    u_ab  = lt_unsigned(opa, opb);
    u_ba  = lt_unsigned(opb, opa);

    res          = '0;
    res[CC_EQ]   = is_eq;
    res[CC_NE]   = !is_eq;
    res[CC_LT]   = s_ab;
    res[CC_GT]   = s_ba;
    res[CC_LTU]  = u_ab;
    res[CC_GTU]  = u_ba;
    res[CC_GE]   = !s_ab;
    res[CC_LE]   = !s_ba;
    res[CC_GEU]  = !u_ab;
    res[CC_LEU]  = !u_ba;
  end

  always_comb begin
    bad_code = 1'b0;
    hit      = 1'b0;
    case (code)
      CC_EQ:   hit = res[CC_EQ];
      CC_NE:   hit = res[CC_NE];
      CC_LT:   hit = res[CC_LT];
      CC_GT:   hit = res[CC_GT];
      CC_LTU:  hit = res[CC_LTU];
      CC_GTU:  hit = res[CC_GTU];
      CC_GE:   hit = res[CC_GE];
      CC_LE:   hit = res[CC_LE];
      CC_GEU:  hit = res[CC_GEU];
      CC_LEU:  hit = res[CC_LEU];
      default: bad_code = 1'b1;
    endcase
  end

endmodule

// File: rtl/cbu_target_gen.sv
module cbu_target_gen #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 10
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] jump_pc
);

  localparam int EXT_W = ADDR_W - OFS_W - 1;

  function automatic logic [ADDR_W-1:0] scale_ofs(input logic [OFS_W-1:0] o);
    return {{EXT_W{o[OFS_W-1]}}, o, 1'b0};
  endfunction

  always_comb begin
    seq_pc  = pc + ADDR_W'(2);
    jump_pc = seq_pc + scale_ofs(ofs);
  end

endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] cmp_lhs,
  input  logic [DATA_W-1:0] cmp_rhs,
  input  logic              br_valid,
  input  logic [CC_W-1:0]   br_cond,
  input  logic [OFS_W-1:0]  br_ofs,
  input  logic [ADDR_W-1:0] pc_in,
  output logic [ADDR_W-1:0] npc_out,
  output logic              npc_valid,
  output logic              taken,
  output logic              illegal
);

  logic [DATA_W-1:0] opa_q, opb_q;
  logic              cond_hit, cond_bad;
  logic [ADDR_W-1:0] seq_pc, jump_pc;

  cbu_operand_latch #(.DATA_W(DATA_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cmp_valid),
    .lhs_in (cmp_lhs),
    .rhs_in (cmp_rhs),
    .lhs_q  (opa_q),
    .rhs_q  (opb_q)
  );

  cbu_cond_eval #(.DATA_W(DATA_W)) u_eval (
    .opa      (opa_q),
    .opb      (opb_q),
    .code     (br_cond),
    .hit      (cond_hit),
    .bad_code (cond_bad)
  );

  cbu_target_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_tgt (
    .pc      (pc_in),
    .ofs     (br_ofs),
    .seq_pc  (seq_pc),
    .jump_pc (jump_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      npc_out   <= '0;
      npc_valid <= 1'b0;
      taken     <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      npc_valid <= br_valid;
      taken     <= br_valid & cond_hit;
      illegal   <= br_valid & cond_bad;
      if (br_valid) npc_out <= cond_hit ? jump_pc : seq_pc;
    end
  end

endmodule

// File: rtl/cmp_branch_unit_chk.sv
module cmp_branch_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_valid,
  input logic [DATA_W-1:0] cmp_lhs,
  input logic [DATA_W-1:0] cmp_rhs,
  input logic              br_valid,
  input logic [3:0]        br_cond,
  input logic [OFS_W-1:0]  br_ofs,
  input logic [ADDR_W-1:0] pc_in,
  input logic [ADDR_W-1:0] npc_out,
  input logic              npc_valid,
  input logic              taken,
  input logic              illegal,
  input logic [DATA_W-1:0] lat_a,
  input logic [DATA_W-1:0] lat_b
);

  localparam int EXT_W = ADDR_W - OFS_W - 1;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> (lat_a == $past(cmp_lhs)) && (lat_b == $past(cmp_rhs)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(lat_a) && $stable(lat_b));

  p_illegal_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_cond > 4'd9) |=> illegal && !taken);

  p_legal_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_cond <= 4'd9) |=> !illegal);

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> npc_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> !npc_valid && !taken && !illegal);

  p_fallthrough_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (npc_valid && !taken) |-> npc_out == $past(pc_in) + ADDR_W'(2));

  p_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (npc_valid && taken) |-> npc_out == $past(pc_in) + ADDR_W'(2)
      + {{EXT_W{$past(br_ofs[OFS_W-1])}}, $past(br_ofs), 1'b0});

endmodule

bind cmp_branch_unit cmp_branch_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_valid (cmp_valid),
  .cmp_lhs   (cmp_lhs),
  .cmp_rhs   (cmp_rhs),
  .br_valid  (br_valid),
  .br_cond   (br_cond),
  .br_ofs    (br_ofs),
  .pc_in     (pc_in),
  .npc_out   (npc_out),
  .npc_valid (npc_valid),
  .taken     (taken),
  .illegal   (illegal),
  .lat_a     (opa_q),
  .lat_b     (opb_q)
);

// File: tb/cmp_branch_unit_bench.sv
module cmp_branch_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_lhs = '0, cmp_rhs = '0;
  logic        br_valid = 1'b0;
  logic [3:0]  br_cond = '0;
  logic [9:0]  br_ofs = '0;
  logic [31:0] pc_in = '0;
  logic [31:0] npc_out;
  logic        npc_valid, taken, illegal;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_branch_unit u_cmp_branch_unit (
    .clk(clk), .rst_n(rst_n),
    .cmp_valid(cmp_valid), .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs),
    .br_valid(br_valid), .br_cond(br_cond), .br_ofs(br_ofs), .pc_in(pc_in),
    .npc_out(npc_out), .npc_valid(npc_valid), .taken(taken), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model of the condition table, built from a sign-flip view of signed order.
  function automatic bit model_hit(input logic [3:0] c,
                                   input logic [31:0] a, input logic [31:0] b);
    logic [31:0] fa, fb;
    fa = a ^ 32'h8000_0000;
    fb = b ^ 32'h8000_0000;
    case (c)
      4'd0: return a == b;
      4'd1: return a != b;
      4'd2: return fa < fb;
      4'd3: return fa > fb;
      4'd4: return a < b;
      4'd5: return a > b;
      4'd6: return fa >= fb;
      4'd7: return fa <= fb;
      4'd8: return a >= b;
      4'd9: return a <= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] model_tgt(input logic [31:0] pc, input logic [9:0] o);
    longint d;
    d = o[9] ? (longint'(o) * 2 - 2048) : longint'(o) * 2;
    return 32'(longint'(pc) + 2 + d);
  endfunction

  task automatic do_cmp(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_lhs = a; cmp_rhs = b;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  // Branch, then check the registered result one edge later.
  task automatic do_br(input logic [3:0] c, input logic [9:0] o, input logic [31:0] pc,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    bit tk, il;
    logic [31:0] exp_npc;
    @(negedge clk);
    br_valid = 1'b1; br_cond = c; br_ofs = o; pc_in = pc;
    @(negedge clk);
    br_valid = 1'b0;
    il = (c > 4'd9);
    tk = model_hit(c, a, b);
    exp_npc = tk ? model_tgt(pc, o) : 32'(pc + 32'd2);
    chk(npc_valid == 1'b1, {tag, " R8 valid"}, 32'(npc_valid), 32'd1);
    chk(taken == tk, {tag, " R3 taken"}, 32'(taken), 32'(tk));
    chk(illegal == il, {tag, " R7 illegal"}, 32'(illegal), 32'(il));
    chk(npc_out == exp_npc, {tag, tk ? " R5 target" : " R6 next"}, npc_out, exp_npc);
  endtask

  initial begin
    logic [31:0] vals [6];
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of the outputs
    chk(npc_valid == 0 && taken == 0 && illegal == 0, "R1 flags",
        {29'd0, npc_valid, taken, illegal}, 32'd0);
    chk(npc_out == 0, "R1 npc", npc_out, 32'd0);
    // R1: reset operands are zero, so EQ is taken and LTU is not
    do_br(4'd0, 10'd4, 32'h100, 32'd0, 32'd0, "R1 eq-zero");
    do_br(4'd4, 10'd4, 32'h100, 32'd0, 32'd0, "R1 ltu-zero");

    // R3, R4, R7: every code against boundary operand pairs
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        do_cmp(vals[i], vals[j]);
        for (int c = 0; c < 16; c++)
          do_br(4'(c), 10'(c * 37 + i), 32'h0000_4000 + 32'(j * 16), vals[i], vals[j], "R4 sweep");
      end
    end

    // R5: every offset, including the address wrap
    do_cmp(32'd7, 32'd7);
    for (int o = 0; o < 1024; o++)
      do_br(4'd0, 10'(o), (o % 2 == 1) ? 32'hFFFF_FFF0 : 32'h0000_0010, 32'd7, 32'd7, "R5 ofs");
    // R6: fall-through wraps too
    do_br(4'd1, 10'd3, 32'hFFFF_FFFE, 32'd7, 32'd7, "R6 wrap");

    // R2: operands hold across idle cycles and branches
    repeat (5) @(negedge clk);
    do_br(4'd0, 10'd1, 32'h200, 32'd7, 32'd7, "R2 hold");

    // R9: compare and branch in the same cycle use the old operands
    do_cmp(32'd3, 32'd3);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_lhs = 32'd1; cmp_rhs = 32'd9;
    br_valid = 1'b1; br_cond = 4'd0; br_ofs = 10'd8; pc_in = 32'h300;
    @(negedge clk);
    cmp_valid = 1'b0; br_valid = 1'b0;
    chk(taken == 1'b1, "R9 old operands taken", 32'(taken), 32'd1);
    chk(npc_out == 32'h312, "R9 old operands npc", npc_out, 32'h312);
    do_br(4'd0, 10'd8, 32'h300, 32'd1, 32'd9, "R9 new operands");
    do_br(4'd2, 10'd8, 32'h300, 32'd1, 32'd9, "R9 new lt");

    // R8: flags drop the cycle after a lone result
    @(negedge clk);
    chk(npc_valid == 0 && taken == 0 && illegal == 0, "R8 idle",
        {29'd0, npc_valid, taken, illegal}, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule